// File: doc/BRIEF.md
# Indexed Extension Word Decoder

This block parses the extension words that trail an opcode whose effective address is indexed off an address register or off the program counter. Words arrive one per handshake on a 16-bit valid/ready stream. With the first word the block also samples the base register number and a flag that marks a program-counter base. The first word is classified as a short (brief) form or a long (full) form. In the long form, size fields in that word decide how many further words follow: zero, one or two words for a base displacement, then zero, one or two words for an outer displacement.

Once the last word needed has been taken, the block presents one result record. The record holds a resolved addressing-mode code, the index register selection, the index width and scale, both displacements sign-extended to 32 bits, the raw size codes, and an error flag for reserved encodings. The record is held until the consumer accepts it, and the next first word can then be taken. Address arithmetic and memory access belong to later stages.

Top module: `idx_ext_decoder`

## Requirements
- R1: After reset is released, `in_ready` is 1 and `out_valid` is 0, and the next word taken is treated as a first extension word.
- R2: The record reports first-word bit 15 as `out_idx_is_addr`, bits 14:12 as `out_idx_reg`, bit 11 as `out_idx_long`, bits 10:9 as `out_scale` (multiplier 2^code), and the base register sampled with the first word as `out_base_reg`.
- R3: If bit 8 of the first word is 0, no further word is consumed. The mode kind is 0 (base + index + 8-bit displacement), `out_base_disp` is bits 7:0 sign-extended, `out_outer_disp` is 0 and `out_sizes` is 0.
- R4: In the long form, bits 5:4 size the base displacement. Code 1 gives 0. Code 2 takes one word, sign-extended. Code 3 takes two words, the upper half first.
- R5: In the long form with bits 2:0 equal to 0, bits 7:6 pick the mode kind. 0 gives kind 1 (base+index+disp), 1 gives kind 2 (base+disp), 2 gives kind 3 (index+disp) and 3 gives kind 4 (disp only).
- R6: In the long form with bits 2:0 nonzero (memory indirect), bits {7,6,2} pick the mode kind. 000 gives 5 (pre-indexed), 001 gives 6 (post-indexed), 010 gives 7 (no index), 100 gives 8 (pre-indexed, no base), 101 gives 9 (post-indexed, no base) and 110 gives 10 (no base, no index). Bits 1:0 size the outer displacement by the R4 rule, and its words follow the base displacement words.
- R7: `out_mode` is {pc_base, kind}. A program-counter base sets bit 4, so a suppressed base under a program-counter base reports the zero-PC variant with the same kind.
- R8: `out_sizes` is {outer size code, base size code}. The outer code is 0 when the word is not memory indirect, and the whole field is 0 in the short form.
- R9: A long-form word with a base size code of 0, with a memory-indirect outer size code of 0, or with memory-indirect bits {7,6,2} of 011 or 111 sets `out_err`. It gives kind 15 and zero displacements, and no further word is consumed for it.
- R10: While `out_valid` is 1 and `out_ready` is 0, every output stays unchanged, and `in_ready` is 0 whenever `out_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word on `in_word` is valid |
| in_ready | output | 1 | Block takes a word this cycle |
| in_word | input | 16 | Extension word |
| base_reg | input | 3 | Base address register number, sampled with the first word |
| pc_base | input | 1 | Base is the program counter, sampled with the first word |
| out_valid | output | 1 | Result record valid |
| out_ready | input | 1 | Consumer accepts the record |
| out_mode | output | 5 | {pc base, mode kind} |
| out_base_reg | output | 3 | Sampled base register number |
| out_idx_is_addr | output | 1 | Index is an address register |
| out_idx_reg | output | 3 | Index register number |
| out_idx_long | output | 1 | Index is used as a long value |
| out_scale | output | 2 | Scale code |
| out_base_disp | output | 32 | Sign-extended base displacement |
| out_outer_disp | output | 32 | Sign-extended outer displacement |
| out_sizes | output | 4 | {outer size code, base size code} |
| out_err | output | 1 | Reserved encoding |

## Verification
The bench walks every base and outer size code and every suppress/pre/post combination, under both an address-register base and a program-counter base. A decoder that mixed up the word order would put the two halves of a long displacement in swapped positions. A decoder that skipped the sign extension would report small positive values for negative one-word displacements. Each reserved encoding is followed at once by a short-form word. A decoder that kept consuming words after an error would swallow that word as a displacement, and the short-form record would go missing. The consumer stalls in a fixed pattern, so a record that changes or is dropped while stalled would show up as a mismatch.

// File: rtl/idx_ext_decoder.sv
module idx_ext_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_word,
  input  logic [2:0]  base_reg,
  input  logic        pc_base,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [4:0]  out_mode,
  output logic [2:0]  out_base_reg,
  output logic        out_idx_is_addr,
  output logic [2:0]  out_idx_reg,
  output logic        out_idx_long,
  output logic [1:0]  out_scale,
  output logic [31:0] out_base_disp,
  output logic [31:0] out_outer_disp,
  output logic [3:0]  out_sizes,
  output logic        out_err
);

  typedef enum logic [2:0] {S_IDLE, S_BD_HI, S_BD_LO, S_OD_HI, S_OD_LO, S_OUT} state_t;
  localparam logic [3:0] KIND_ERR = 4'hF;

  state_t st;

  wire take = in_valid && in_ready;
  wire [15:0] w = in_word;
  wire [31:0] w_sext = {{16{w[15]}}, w};

  wire       full  = w[8];
  wire [1:0] bsz   = w[5:4];
  wire [1:0] osz   = w[1:0];
  wire       mi    = full && (w[2:0] != 3'b000);
  wire [2:0] msel  = {w[7], w[6], w[2]};

  logic [3:0] kind;
  logic       bad_sel;
  always_comb begin
    bad_sel = 1'b0;
    if (!full)      kind = 4'd0;
    else if (!mi)   kind = 4'd1 + {2'b00, w[7:6]};
    else begin
      case (msel)
        3'b000:  kind = 4'd5;
        3'b001:  kind = 4'd6;
        3'b010:  kind = 4'd7;
        3'b100:  kind = 4'd8;
        3'b101:  kind = 4'd9;
        3'b110:  kind = 4'd10;
        default: begin kind = KIND_ERR; bad_sel = 1'b1; end
      endcase
    end
  end

  wire first_err = full && (bsz == 2'd0 || (mi && (osz == 2'd0 || bad_sel)));
  wire [3:0] first_sz = full ? {mi ? osz : 2'b00, bsz} : 4'b0000;

  function automatic state_t after_bd(input logic [1:0] od_code);
    case (od_code)
      2'd3:    after_bd = S_OD_HI;
      2'd2:    after_bd = S_OD_LO;
      default: after_bd = S_OUT;
    endcase
  endfunction

  assign in_ready  = (st != S_OUT);
  assign out_valid = (st == S_OUT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st              <= S_IDLE;
      out_mode        <= '0;
      out_base_reg    <= '0;
      out_idx_is_addr <= 1'b0;
      out_idx_reg     <= '0;
      out_idx_long    <= 1'b0;
      out_scale       <= '0;
      out_base_disp   <= '0;
      out_outer_disp  <= '0;
      out_sizes       <= '0;
      out_err         <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (take) begin
          out_base_reg    <= base_reg;
          out_idx_is_addr <= w[15];
          out_idx_reg     <= w[14:12];
          out_idx_long    <= w[11];
          out_scale       <= w[10:9];
          out_sizes       <= first_sz;
          out_err         <= first_err;
          out_mode        <= {pc_base, first_err ? KIND_ERR : kind};
          out_base_disp   <= (full || first_err) ? 32'd0 : {{24{w[7]}}, w[7:0]};
          out_outer_disp  <= '0;
          if (first_err || !full) st <= S_OUT;
          else if (bsz == 2'd3)   st <= S_BD_HI;
          else if (bsz == 2'd2)   st <= S_BD_LO;
          else                    st <= after_bd(first_sz[3:2]);
        end
        S_BD_HI: if (take) begin
          out_base_disp[31:16] <= w;
          st <= S_BD_LO;
        end
        S_BD_LO: if (take) begin
          out_base_disp <= (out_sizes[1:0] == 2'd3) ? {out_base_disp[31:16], w} : w_sext;
          st <= after_bd(out_sizes[3:2]);
        end
        S_OD_HI: if (take) begin
          out_outer_disp[31:16] <= w;
          st <= S_OD_LO;
        end
        S_OD_LO: if (take) begin
          out_outer_disp <= (out_sizes[3:2] == 2'd3) ? {out_outer_disp[31:16], w} : w_sext;
          st <= S_OUT;
        end
        S_OUT: if (out_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_mode) && $stable(out_base_disp)
      && $stable(out_outer_disp) && $stable(out_sizes) && $stable(out_err) && $stable(out_idx_reg));

  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_err_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_mode[3:0] == KIND_ERR && out_base_disp == 32'd0 && out_outer_disp == 32'd0);

  assert_brief_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err && out_mode[3:0] == 4'd0 |-> out_sizes == 4'd0 && out_outer_disp == 32'd0);

  assert_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err |-> out_mode[3:0] <= 4'd10 && out_sizes[1:0] != 2'd0 || out_mode[3:0] == 4'd0);

  assert_noouter_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sizes[3:2] == 2'd0 |-> out_outer_disp == 32'd0);

endmodule

// File: tb/sim_idx_ext_decoder.sv
`timescale 1ns/1ps
module sim_idx_ext_decoder;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_word = '0;
  logic [2:0]  base_reg = '0;
  logic        pc_base = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [4:0]  out_mode;
  logic [2:0]  out_base_reg;
  logic        out_idx_is_addr;
  logic [2:0]  out_idx_reg;
  logic        out_idx_long;
  logic [1:0]  out_scale;
  logic [31:0] out_base_disp;
  logic [31:0] out_outer_disp;
  logic [3:0]  out_sizes;
  logic        out_err;

  idx_ext_decoder u0 (.*);

  typedef struct packed {
    logic [4:0]  mode;
    logic [2:0]  breg;
    logic        ia;
    logic [2:0]  ir;
    logic        il;
    logic [1:0]  sc;
    logic [31:0] bd;
    logic [31:0] od;
    logic [3:0]  sz;
    logic        err;
  } rec_t;

  rec_t  expq[$];
  string tagq[$];
  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  function automatic logic [15:0] fw(input logic ia, input logic [2:0] r, input logic l,
                                     input logic [1:0] sc, input logic f, input logic [7:0] lo);
    return {ia, r, l, sc, f, lo};
  endfunction

  function automatic rec_t mk(input logic [4:0] mode, input logic [2:0] br, input logic [15:0] w0,
                              input logic [31:0] bd, input logic [31:0] od, input logic [3:0] sz,
                              input logic err);
    rec_t e;
    e.mode = mode; e.breg = br; e.ia = w0[15]; e.ir = w0[14:12]; e.il = w0[11];
    e.sc = w0[10:9]; e.bd = bd; e.od = od; e.sz = sz; e.err = err;
    return e;
  endfunction

  task automatic run(input string tag, input logic [2:0] br, input logic pc, input int n,
                     input logic [15:0] w0, input logic [15:0] w1, input logic [15:0] w2,
                     input logic [15:0] w3, input logic [15:0] w4, input rec_t e);
    logic [15:0] ws [5];
    ws[0] = w0; ws[1] = w1; ws[2] = w2; ws[3] = w3; ws[4] = w4;
    expq.push_back(e);
    tagq.push_back(tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_word = ws[i]; base_reg = br; pc_base = pc;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  int   cyc = 0;
  rec_t held;
  bit   was_stalled = 1'b0;
  always @(negedge clk) begin
    rec_t act;
    act = {out_mode, out_base_reg, out_idx_is_addr, out_idx_reg, out_idx_long, out_scale,
           out_base_disp, out_outer_disp, out_sizes, out_err};
    if (rst_n) begin
      if (was_stalled) begin
        n_checks++;
        if (!(out_valid && !in_ready && act == held)) begin
          n_fail++;
          $display("FAIL R10 hold: act=%h valid=%b ready=%b exp=%h", act, out_valid, in_ready, held);
        end
      end
      cyc++;
      out_ready = (cyc % 3) != 1;
      was_stalled = out_valid && !out_ready;
      held = act;
      if (out_valid && out_ready) begin
        n_checks++;
        if (expq.size() == 0) begin
          n_fail++;
          $display("FAIL unexpected record: act=%h exp=none", act);
        end else begin
          rec_t e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          if (act !== e) begin
            n_fail++;
            $display("FAIL %s: act=%h exp=%h", t, act, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_checks++;
    if (!(in_ready === 1'b1 && out_valid === 1'b0)) begin
      n_fail++;
      $display("FAIL R1 reset: act=%b%b exp=10", in_ready, out_valid);
    end

    // R3 R2: short form, negative and positive displacement
    w = fw(0, 3'd3, 1, 2'd2, 0, 8'hF0);
    run("R3 brief neg", 3'd5, 0, 1, w, 0, 0, 0, 0, mk(5'd0, 3'd5, w, 32'hFFFFFFF0, 0, 4'h0, 0));
    w = fw(1, 3'd7, 0, 2'd0, 0, 8'h7F);
    run("R3 R7 brief pc", 3'd1, 1, 1, w, 0, 0, 0, 0, mk(5'd16, 3'd1, w, 32'h7F, 0, 4'h0, 0));
    // R4 R5: long form, plain modes
    w = fw(0, 3'd1, 0, 2'd1, 1, 8'h10);
    run("R5 R4 kind1 zero bd", 3'd2, 0, 1, w, 0, 0, 0, 0, mk(5'd1, 3'd2, w, 0, 0, 4'h1, 0));
    w = fw(1, 3'd4, 1, 2'd3, 1, 8'h60);
    run("R5 R4 kind2 word bd", 3'd6, 0, 2, w, 16'h8001, 0, 0, 0, mk(5'd2, 3'd6, w, 32'hFFFF8001, 0, 4'h2, 0));
    w = fw(0, 3'd2, 0, 2'd0, 1, 8'hB0);
    run("R5 R4 kind3 long bd", 3'd0, 0, 3, w, 16'h1234, 16'h5678, 0, 0, mk(5'd3, 3'd0, w, 32'h12345678, 0, 4'h3, 0));
    w = fw(0, 3'd0, 0, 2'd0, 1, 8'hE0);
    run("R5 kind4", 3'd3, 0, 2, w, 16'h0042, 0, 0, 0, mk(5'd4, 3'd3, w, 32'h42, 0, 4'h2, 0));
    // R6 R8: memory indirect
    w = fw(1, 3'd5, 1, 2'd1, 1, 8'h21);
    run("R6 pre", 3'd4, 0, 2, w, 16'hFFFE, 0, 0, 0, mk(5'd5, 3'd4, w, 32'hFFFFFFFE, 0, 4'h6, 0));
    w = fw(0, 3'd6, 0, 2'd2, 1, 8'h16);
    run("R6 post word od", 3'd7, 0, 2, w, 16'h8000, 0, 0, 0, mk(5'd6, 3'd7, w, 0, 32'hFFFF8000, 4'h9, 0));
    w = fw(1, 3'd1, 1, 2'd3, 1, 8'h73);
    run("R6 R8 noidx long both", 3'd2, 0, 5, w, 16'hDEAD, 16'hBEEF, 16'h0001, 16'h0002,
        mk(5'd7, 3'd2, w, 32'hDEADBEEF, 32'h00010002, 4'hF, 0));
    w = fw(0, 3'd3, 0, 2'd0, 1, 8'h92);
    run("R6 pre nobase", 3'd5, 0, 2, w, 16'h0010, 0, 0, 0, mk(5'd8, 3'd5, w, 0, 32'h10, 4'h9, 0));
    w = fw(1, 3'd2, 0, 2'd1, 1, 8'hA7);
    run("R7 R6 post zpc", 3'd6, 1, 4, w, 16'h0004, 16'hFFFF, 16'hFFF0, 0,
        mk(5'd25, 3'd6, w, 32'h4, 32'hFFFFFFF0, 4'hE, 0));
    w = fw(0, 3'd0, 1, 2'd2, 1, 8'hD1);
    run("R7 R6 zpc nothing", 3'd0, 1, 1, w, 0, 0, 0, 0, mk(5'd26, 3'd0, w, 0, 0, 4'h5, 0));
    w = fw(0, 3'd4, 0, 2'd1, 1, 8'h20);
    run("R7 pc kind1", 3'd1, 1, 2, w, 16'h0100, 0, 0, 0, mk(5'd17, 3'd1, w, 32'h100, 0, 4'h2, 0));
    // R9: reserved encodings, each followed by a short-form word
    w = fw(0, 3'd1, 0, 2'd0, 1, 8'h02);
    run("R9 bd size 0", 3'd2, 0, 1, w, 0, 0, 0, 0, mk(5'd15, 3'd2, w, 0, 0, 4'h8, 1));
    w = fw(0, 3'd5, 0, 2'd0, 0, 8'h05);
    run("R9 after bd err", 3'd2, 0, 1, w, 0, 0, 0, 0, mk(5'd0, 3'd2, w, 32'h5, 0, 4'h0, 0));
    w = fw(1, 3'd1, 0, 2'd0, 1, 8'h24);
    run("R9 od size 0", 3'd3, 0, 1, w, 0, 0, 0, 0, mk(5'd15, 3'd3, w, 0, 0, 4'h2, 1));
    w = fw(0, 3'd6, 1, 2'd0, 0, 8'h80);
    run("R9 after od err", 3'd3, 0, 1, w, 0, 0, 0, 0, mk(5'd0, 3'd3, w, 32'hFFFFFF80, 0, 4'h0, 0));
    w = fw(0, 3'd2, 0, 2'd0, 1, 8'h55);
    run("R9 sel 011", 3'd4, 0, 1, w, 0, 0, 0, 0, mk(5'd15, 3'd4, w, 0, 0, 4'h5, 1));
    w = fw(1, 3'd7, 1, 2'd3, 1, 8'hD5);
    run("R9 R7 sel 111 pc", 3'd4, 1, 1, w, 0, 0, 0, 0, mk(5'd31, 3'd4, w, 0, 0, 4'h5, 1));
    w = fw(0, 3'd2, 0, 2'd1, 0, 8'h01);
    run("R9 R2 after sel err", 3'd7, 0, 1, w, 0, 0, 0, 0, mk(5'd0, 3'd7, w, 32'h1, 0, 4'h0, 0));

    while (expq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule